// File: doc/BRIEF.md
# Fetch-Decode Instruction Cycle Controller

This block runs the front half of every instruction for a small 16-bit accumulator machine. A sequence counter steps through four timing phases. In those phases the block copies the program counter into the address register and reads the instruction word from memory. It then advances the program counter, splits the word into its fields and decodes the 3-bit opcode into eight one-hot lines. When the instruction is an indirect memory-reference, the block also fetches the effective address.

At the end of the fourth phase the block reports one of four classes and gives a single-cycle `decode_done_o` pulse. It then waits for the execute logic, which answers with `exec_done_i` to start the next fetch. While `halt_i` is high the block stays idle and does not start new cycles.

The memory is synchronous and word-addressed, with one cycle of read latency. The block presents each read address one cycle before the register that takes the returned data.

Top module: `insn_cycle_ctrl`

## Requirements
- R1: While `rst_ni` is low, PC, AR, IR, the indirect flag and the decode lines are zero, `timing_o` is 4'b0001 (T0) and `decode_done_o` is low.
- R2: The phases run T0, T1, T2, T3 for one cycle each, with `timing_o` bit n marking Tn. After T3 the block enters a wait state in which `timing_o` is all zero.
- R3: During T0 `mem_rd_o` is high with `mem_addr_o` equal to PC, and AR takes the value of PC at the end of T0.
- R4: At the end of T1, IR takes the read data and PC increments by one.
- R5: At the end of T2, the bit of `dec_o` indexed by IR[14:12] is set and no other bit is. AR takes IR[11:0] and the indirect flag takes IR[15].
- R6: `class_o` is {D7, I}: 2'b00 for direct memory-reference, 2'b01 for indirect memory-reference, 2'b10 for register-reference and 2'b11 for input/output.
- R7: Only an indirect memory-reference (opcode not 3'b111, IR[15]=1) issues a read during T2, at address IR[11:0], and AR then takes the returned data bits 11:0 at the end of T3. Every other instruction leaves AR at IR[11:0].
- R8: `decode_done_o` is high for exactly one cycle, in the first cycle after T3.
- R9: The wait state holds until `exec_done_i` is seen with `halt_i` low, and the next cycle is T0.
- R10: While `halt_i` is high in the wait state, `exec_done_i` has no effect, so `timing_o` stays zero and PC does not change. After `halt_i` drops, an `exec_done_i` resumes at T0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_done_i | input | 1 | Execute logic finished; start the next fetch |
| halt_i | input | 1 | Keep the sequencer idle in the wait state |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | AW (12) | Memory word address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the strobe |
| timing_o | output | 4 | One-hot timing phase T0..T3 |
| dec_o | output | 2**OPW (8) | One-hot opcode decode D0..D7 |
| class_o | output | 2 | Instruction class {D7, I} |
| decode_done_o | output | 1 | One-cycle pulse when the class is valid |
| pc_o | output | AW (12) | Program counter |
| ar_o | output | AW (12) | Address register |
| ir_o | output | 16 | Instruction register |
| ind_o | output | 1 | Indirect flag I |

## Verification
The bench builds the block with its default parameters: a 12-bit address and a 3-bit opcode, which give a 16-bit word and eight decode lines. With this build, a table of eight instructions covers every class and both values of the mode bit. It uses opcodes 0, 1, 2, 3, 6 and 7, and it includes an input/output word whose address field points at a valid pointer that must not be followed. A small memory model in the bench places the instructions at consecutive addresses, so the program counter sequence and the phase trace are checked for each instruction. The halt and resume directed tests follow the table.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [2:0] {
    ST_T0   = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_WAIT = 3'd4
  } sc_e;
endpackage

// File: rtl/icc_seq.sv
module icc_seq
  import icc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       exec_done_i,
  input  logic       halt_i,
  output sc_e        sc_o,
  output logic [3:0] timing_o,
  output logic       done_o
);
  sc_e  sc_q, sc_d;
  logic done_q;

  always_comb begin
    sc_d = sc_q;
    unique case (sc_q)
      ST_T0:   sc_d = ST_T1;
      ST_T1:   sc_d = ST_T2;
      ST_T2:   sc_d = ST_T3;
      ST_T3:   sc_d = ST_WAIT;
      ST_WAIT: if (exec_done_i && !halt_i) sc_d = ST_T0;
      default: sc_d = ST_T0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sc_q   <= ST_T0;
      done_q <= 1'b0;
    end else begin
      sc_q   <= sc_d;
      done_q <= (sc_q == ST_T3);
    end
  end

  for (genvar t = 0; t < 4; t++) begin : g_tim
    assign timing_o[t] = (sc_q == sc_e'(t));
  end

  assign sc_o   = sc_q;
  assign done_o = done_q;

  // R2
  tim_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(timing_o));
  // R2
  t3_to_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timing_o[3] |=> (timing_o == 4'b0000));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  halt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_q == ST_WAIT && halt_i) |=> (timing_o == 4'b0000));
  // R9
  resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_q == ST_WAIT && exec_done_i && !halt_i) |=> timing_o[0]);
endmodule

// File: rtl/icc_decode.sv
module icc_decode #(
  parameter int unsigned OPW = 3,
  localparam int unsigned DW = 1 << OPW
) (
  input  logic [OPW-1:0] op_i,
  output logic [DW-1:0]  dec_o
);
  for (genvar k = 0; k < DW; k++) begin : g_dec
    assign dec_o[k] = (op_i == OPW'(k));
  end

  // R5
  always_comb dec_onehot_chk: assert ($onehot(dec_o));
endmodule

// File: rtl/icc_regs.sv
module icc_regs
  import icc_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned OPW = 3,
  localparam int unsigned WW = AW + OPW + 1,
  localparam int unsigned DW = 1 << OPW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  sc_e            sc_i,
  input  logic [WW-1:0]  mem_rdata_i,
  input  logic [DW-1:0]  dec_next_i,
  output logic [OPW-1:0] op_o,
  output logic           mem_rd_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [AW-1:0]  pc_o,
  output logic [AW-1:0]  ar_o,
  output logic [WW-1:0]  ir_o,
  output logic           ind_o,
  output logic [DW-1:0]  dec_o
);
  logic [AW-1:0] pc_q, ar_q;
  logic [WW-1:0] ir_q;
  logic          ind_q;
  logic [DW-1:0] dec_q;
  logic          ir_memref, ir_ind;

  assign op_o      = ir_q[WW-2 -: OPW];
  assign ir_ind    = ir_q[WW-1];
  assign ir_memref = (op_o != {OPW{1'b1}});

  // address is issued one cycle ahead of the register that takes the data
  assign mem_rd_o   = (sc_i == ST_T0) || (sc_i == ST_T2 && ir_memref && ir_ind);
  assign mem_addr_o = (sc_i == ST_T0) ? pc_q : ir_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      ar_q  <= '0;
      ir_q  <= '0;
      ind_q <= 1'b0;
      dec_q <= '0;
    end else begin
      unique case (sc_i)
        ST_T0: ar_q <= pc_q;
        ST_T1: begin
          ir_q <= mem_rdata_i;
          pc_q <= pc_q + AW'(1);
        end
        ST_T2: begin
          dec_q <= dec_next_i;
          ar_q  <= ir_q[AW-1:0];
          ind_q <= ir_ind;
        end
        ST_T3: if (!dec_q[DW-1] && ind_q) ar_q <= mem_rdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  assign pc_o  = pc_q;
  assign ar_o  = ar_q;
  assign ir_o  = ir_q;
  assign ind_o = ind_q;
  assign dec_o = dec_q;

  // R3
  ar_from_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i == ST_T0) |=> (ar_q == $past(pc_q)));
  // R4
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i == ST_T1) |=> (pc_q == $past(pc_q) + AW'(1)));
  // R10
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i == ST_WAIT) |=> $stable(pc_q));
  // R7
  rd_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (sc_i == ST_T0 || sc_i == ST_T2));
  // R7
  ar_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_i == ST_T3 && !(ind_q && !dec_q[DW-1])) |=> $stable(ar_q));
endmodule

// File: rtl/insn_cycle_ctrl.sv
module insn_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int unsigned AW  = 12,
  parameter int unsigned OPW = 3,
  localparam int unsigned WW = AW + OPW + 1,
  localparam int unsigned DW = 1 << OPW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exec_done_i,
  input  logic          halt_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [WW-1:0] mem_rdata_i,
  output logic [3:0]    timing_o,
  output logic [DW-1:0] dec_o,
  output logic [1:0]    class_o,
  output logic          decode_done_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] ar_o,
  output logic [WW-1:0] ir_o,
  output logic          ind_o
);
  sc_e            sc;
  logic [OPW-1:0] op;
  logic [DW-1:0]  dec_next;

  icc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_done_i (exec_done_i),
    .halt_i      (halt_i),
    .sc_o        (sc),
    .timing_o    (timing_o),
    .done_o      (decode_done_o)
  );

  icc_decode #(.OPW(OPW)) u_dec (
    .op_i  (op),
    .dec_o (dec_next)
  );

  icc_regs #(.AW(AW), .OPW(OPW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sc_i        (sc),
    .mem_rdata_i (mem_rdata_i),
    .dec_next_i  (dec_next),
    .op_o        (op),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .pc_o        (pc_o),
    .ar_o        (ar_o),
    .ir_o        (ir_o),
    .ind_o       (ind_o),
    .dec_o       (dec_o)
  );

  assign class_o = {dec_o[DW-1], ind_o};

  // R6
  class_io_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_done_o |-> (class_o[1] == (ir_o[WW-2 -: OPW] == {OPW{1'b1}})));
  // R5
  ind_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decode_done_o |-> (ind_o == ir_o[WW-1]));
endmodule

// File: tb/sim_insn_cycle_ctrl.sv
module sim_insn_cycle_ctrl;
  localparam int AW = 12;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          exec_done = 1'b0;
  logic          halt = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_rdata = '0;
  logic [3:0]    timing;
  logic [7:0]    dec;
  logic [1:0]    cls;
  logic          ddone;
  logic [AW-1:0] pc, ar;
  logic [WW-1:0] ir;
  logic          ind;

  int errs = 0, checks = 0;
  logic [WW-1:0] mem [256];

  localparam logic [15:0] VEC [8] = '{16'h0040, 16'h9041, 16'h2042, 16'hB043,
                                      16'h7044, 16'hF045, 16'h6046, 16'hE047};

  always #2.5 clk = ~clk;

  insn_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .exec_done_i(exec_done), .halt_i(halt),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .timing_o(timing), .dec_o(dec), .class_o(cls), .decode_done_o(ddone),
    .pc_o(pc), .ar_o(ar), .ir_o(ir), .ind_o(ind)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // waits for decode_done while tracing the phases; returns 1 if T0..T3 seen in order
  task automatic run_to_done(output bit seq_ok);
    int n = 0;
    seq_ok = 1'b1;
    while (!ddone) begin
      if (n > 3 || timing !== 4'(1 << n)) seq_ok = 1'b0;
      n++;
      @(negedge clk);
      if (n > 20) break;
    end
    if (n != 4) seq_ok = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ok;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int k = 0; k < 8; k++) begin
      mem[k] = VEC[k];
      mem[8'h40 + k] = 16'h5100 + 16'(k * 16'h0123);
    end
    mem[8] = 16'h0048;

    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 ar", 32'(ar), 0);
    chk("R1 ir", 32'(ir), 0);
    chk("R1 ind/dec", {ind, dec}, 0);
    chk("R1 timing", 32'(timing), 32'h1);
    chk("R1 done", 32'(ddone), 0);
    chk("R3 rd at T0", {mem_rd, 4'h0, mem_addr}, {1'b1, 4'h0, 12'h000});
    rst_ni = 1'b1;

    for (int k = 0; k < 8; k++) begin
      logic [2:0]  op;
      logic        ib;
      logic [11:0] exp_ar;
      op = VEC[k][14:12];
      ib = VEC[k][15];
      exp_ar = (op != 3'd7 && ib) ? mem[8'h40 + k][11:0] : VEC[k][11:0];
      run_to_done(ok);
      chk("R2 phase order", 32'(ok), 1);
      chk("R4 ir", 32'(ir), 32'(VEC[k]));
      chk("R4 pc", 32'(pc), 32'(k + 1));
      chk("R5 dec", 32'(dec), 32'(1 << op));
      chk("R5 ind", 32'(ind), 32'(ib));
      chk("R6 class", 32'(cls), 32'({op == 3'd7, ib}));
      chk("R7 ar", 32'(ar), 32'(exp_ar));
      chk("R2 wait timing", 32'(timing), 0);
      @(negedge clk);
      chk("R8 done one cycle", 32'(ddone), 0);
      chk("R9 holds without exec_done", 32'(timing), 0);
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
      chk("R9 resume T0", 32'(timing), 32'h1);
      chk("R3 fetch addr", {mem_rd, 4'h0, mem_addr}, {1'b1, 4'h0, 12'(k + 1)});
    end

    // halt test on the ninth instruction
    run_to_done(ok);
    chk("R2 phase order", 32'(ok), 1);
    halt = 1'b1;
    exec_done = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R10 idle timing", 32'(timing), 0);
    end
    chk("R10 pc held", 32'(pc), 32'd9);
    chk("R10 no done", 32'(ddone), 0);
    exec_done = 1'b0;
    halt = 1'b0;
    @(negedge clk);
    chk("R10 still waiting", 32'(timing), 0);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    chk("R10 resume T0", 32'(timing), 32'h1);
    run_to_done(ok);
    chk("R2 phase order after halt", 32'(ok), 1);
    chk("R4 pc after halt", 32'(pc), 32'd10);

    finish_run();
  end
endmodule